// File: doc/BRIEF.md
# Nine-Bit Command/Data Serial Writer

This block sends single bytes to a display controller over a three-wire serial link that only writes. The three wires are an active-low chip select, a serial clock and a serial data line. Every transfer is a nine-bit frame. The first bit is a flag that marks the byte as a command or as parameter data. The eight bits of the byte follow, most significant bit first. Because the flag travels inside the frame, the link needs no separate command/data wire.

Requests arrive on a valid/ready port. A request holds a two-bit kind code and a byte. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so an upstream source may hold `in_valid` and its payload until it sees ready. Requests offered while the block is busy are not taken and cause no action. Kind code 0 sends a command frame and kind code 1 sends a data frame. Codes 2 and 3 are taken off the port and then thrown away: no frame is sent for them.

Each line phase lasts `HALF_PERIOD_CYCLES` system clocks. A value of 100 at 50 MHz gives phases of about 2 µs. When a frame ends, `done_o` pulses high in the same cycle that chip select is released.

Top module: `ser9_writer`

## Requirements
- R1: After reset, `cs_n_o`, `sclk_o` and `sdo_o` are all 1, `busy_o` is 0, `in_ready` is 1 and `done_o` is 0.
- R2: An accepted request with kind 0 or 1 produces exactly nine rising edges on `sclk_o` while `cs_n_o` is low. Sampled on those rising edges, `sdo_o` carries first the flag (bit 0 of `in_kind`: 0 means command, 1 means data) and then `in_byte` from bit 7 down to bit 0.
- R3: `cs_n_o` goes low in the cycle after acceptance. It stays low for `HALF_PERIOD_CYCLES` cycles, with `sclk_o` and `sdo_o` high, before the first falling edge of `sclk_o`.
- R4: Each bit has a low phase of `sclk_o` lasting `HALF_PERIOD_CYCLES` cycles, during which `sdo_o` is set up, followed by a high phase of the same length. `sdo_o` does not change while `sclk_o` is high.
- R5: `HALF_PERIOD_CYCLES` cycles after the ninth rising edge, `cs_n_o` returns high and `sdo_o` is high. Whenever `cs_n_o` is high, `sclk_o` and `sdo_o` are high. Chip select stays low for 19 × `HALF_PERIOD_CYCLES` cycles per frame.
- R6: `done_o` is high for exactly one cycle per frame. That cycle is the first one with `cs_n_o` high again, and `busy_o` falls in the same cycle.
- R7: A request with kind 2 or 3 is accepted (`in_ready` is 1 at that edge), but `cs_n_o` stays high, `busy_o` stays 0 and no `done_o` pulse follows.
- R8: `in_ready` equals the inverse of `busy_o`. A request offered while busy is not taken: the running frame is unchanged and no extra frame follows.
- R9: A request held valid during a frame is accepted at the edge where `done_o` is high. Chip select is then high for exactly one cycle between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request (idle) |
| in_kind | input | 2 | 0 command, 1 data, 2/3 rejected |
| in_byte | input | DATA_W | Byte to send |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when a frame completes |
| cs_n_o | output | 1 | Serial chip select, active low |
| sclk_o | output | 1 | Serial clock, idle high; the receiver samples on rising edges |
| sdo_o | output | 1 | Serial data, idle high |

## Verification
The assertions check the following on every cycle:
- the line levels while chip select is high;
- that data holds still through each clock-high phase;
- that the done pulse is a single cycle aligned with chip-select release;
- that a rejected kind never opens a frame;
- that the phase timer's ticks and the shift count stay in range.

Only the bench scenarios can show the content of each frame as decoded on the rising edges: the flag, then the byte, most significant bit first. They also show the exact setup, phase and frame lengths, the single idle cycle between back-to-back frames, and that requests offered while busy leave the frame unchanged.

// File: rtl/ser9_pkg.sv
package ser9_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } ser9_state_e;

  localparam logic [1:0] KIND_CMD  = 2'd0;
  localparam logic [1:0] KIND_DATA = 2'd1;

  function automatic logic kind_is_valid(input logic [1:0] kind);
    return (kind == KIND_CMD) || (kind == KIND_DATA);
  endfunction

endpackage

// File: rtl/ser9_phase_timer.sv
module ser9_phase_timer #(
  parameter int HALF = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HALF > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    end
  endgenerate

endmodule

// File: rtl/ser9_frame_shift.sv
module ser9_frame_shift #(
  parameter int FW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_word,
  input  logic          shift,
  output logic          cur_bit,
  output logic          next_bit,
  output logic          last
);
  localparam int BW = $clog2(FW);

  logic [FW-1:0] sh_q;
  logic [BW-1:0] left_q;

  assign cur_bit  = sh_q[FW-1];
  assign next_bit = sh_q[FW-2];
  assign last     = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= load_word;
      left_q <= BW'(FW - 1);
    end else if (shift) begin
      sh_q   <= {sh_q[FW-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  AST_NO_EXTRA_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last); // R2

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift); // R8

endmodule

// File: rtl/ser9_writer.sv
module ser9_writer
  import ser9_pkg::*;
#(
  parameter int HALF_PERIOD_CYCLES = 100,
  parameter int DATA_W             = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_byte,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              sdo_o
);
  localparam int FW = DATA_W + 1;

  ser9_state_e state_q, state_nx;
  logic tick, cur_bit, next_bit, last;
  logic accept, start, shift;
  logic cs_n_q, sclk_q, sdo_q, done_q;
  logic sdo_nx;

  assign accept = in_valid && in_ready;
  assign start  = accept && kind_is_valid(in_kind);
  assign shift  = (state_q == ST_HIGH) && tick && !last;

  ser9_phase_timer #(.HALF(HALF_PERIOD_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q != ST_IDLE),
    .tick (tick)
  );

  ser9_frame_shift #(.FW(FW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_word({in_kind[0], in_byte}),
    .shift    (shift),
    .cur_bit  (cur_bit),
    .next_bit (next_bit),
    .last     (last)
  );

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_nx = ST_SETUP;
      ST_SETUP: if (tick)  state_nx = ST_LOW;
      ST_LOW:   if (tick)  state_nx = ST_HIGH;
      ST_HIGH:  if (tick)  state_nx = last ? ST_IDLE : ST_LOW;
      default:             state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_nx)
      ST_LOW: begin
        if (state_q == ST_SETUP)     sdo_nx = cur_bit;
        else if (state_q == ST_HIGH) sdo_nx = next_bit;
        else                         sdo_nx = sdo_q;
      end
      ST_HIGH: sdo_nx = sdo_q;
      default: sdo_nx = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      sdo_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      cs_n_q  <= (state_nx == ST_IDLE);
      sclk_q  <= (state_nx != ST_LOW);
      sdo_q   <= sdo_nx;
      done_q  <= (state_q == ST_HIGH) && tick && last;
    end
  end

  assign in_ready = (state_q == ST_IDLE);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;
  assign sdo_o    = sdo_q;

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (sclk_o && sdo_o)); // R5

  AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && sclk_o && $past(sclk_o) && !$past(cs_n_o)) |-> $stable(sdo_o)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !$past(cs_n_o))); // R6

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind[1]) |=> (cs_n_o && !busy_o)); // R7

  AST_BUSY_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> !cs_n_o); // R3

endmodule

// File: tb/tb_ser9_writer.sv
module tb_ser9_writer;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic [7:0] in_byte = 8'd0;
  logic in_ready, busy_o, done_o, cs_n_o, sclk_o, sdo_o;

  int n_checks = 0;
  int n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser9_writer #(.HALF_PERIOD_CYCLES(H), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_byte(in_byte), .busy_o(busy_o), .done_o(done_o),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_o(sdo_o)
  );

  // serial line decoder
  logic       prev_cs = 1'b1, prev_sclk = 1'b1, prev_sdo = 1'b1;
  logic       in_setup = 1'b0;
  logic [8:0] cap = '0;
  logic [8:0] frames [8];
  int         nbits_q [8];
  int nbits = 0, ph_run = 0, low_run = 0, high_run = 1000;
  int setup_last = 0, low_last = 0, gap_last = 0;
  int bad_phase = 0, sdo_hi_chg = 0, idle_bad = 0, fcnt = 0, done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) done_cnt++;
      if (!cs_n_o) begin
        if (prev_cs) begin
          low_run = 1; in_setup = 1'b1; ph_run = 1; cap = '0; nbits = 0;
          gap_last = high_run;
        end else begin
          low_run++;
          if (sclk_o != prev_sclk) begin
            if (in_setup) begin setup_last = ph_run; in_setup = 1'b0; end
            else if (ph_run != H) bad_phase++;
            ph_run = 1;
            if (sclk_o) begin cap = {cap[7:0], sdo_o}; nbits++; end
          end else begin
            ph_run++;
            if (sclk_o && !in_setup && (sdo_o != prev_sdo)) sdo_hi_chg++;
          end
        end
      end else begin
        if (!prev_cs) begin
          if (ph_run != H) bad_phase++;
          frames[fcnt % 8] = cap;
          nbits_q[fcnt % 8] = nbits;
          low_last = low_run;
          fcnt++;
          high_run = 1;
        end else high_run++;
        if (!sclk_o || !sdo_o) idle_bad++;
      end
      prev_cs = cs_n_o; prev_sclk = sclk_o; prev_sdo = sdo_o;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 5000) begin @(negedge clk); cyc++; end
    #1;
  endtask

  task automatic frame_checks(input string tag, input logic [8:0] exp_word);
    int idx;
    idx = (fcnt - 1) % 8;
    check({tag, " R2 word"}, int'(frames[idx]), int'(exp_word));
    check({tag, " R2 bit count"}, nbits_q[idx], 9);
    check({tag, " R3 setup"}, setup_last, H);
    check({tag, " R5 cs low length"}, low_last, 19 * H);
    check({tag, " R6 busy low at done"}, int'(busy_o), 0);
    @(negedge clk); #1;
    check({tag, " R6 done width"}, int'(done_o), 0);
  endtask

  task automatic send_one(input logic [1:0] kind, input logic [7:0] b, input string tag);
    int cyc, f0, d0;
    f0 = fcnt; d0 = done_cnt;
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_byte = b;
    check({tag, " R8 ready before accept"}, int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check({tag, " R3 cs low after accept"}, int'(cs_n_o), 0);
    wait_done(cyc);
    check({tag, " R6 one done"}, done_cnt - d0, 1);
    check({tag, " frame count"}, fcnt - f0, 1);
    frame_checks(tag, {kind[0], b});
  endtask

  task automatic test_reset();
    #1;
    check("R1 cs_n", int'(cs_n_o), 1);
    check("R1 sclk", int'(sclk_o), 1);
    check("R1 sdo", int'(sdo_o), 1);
    check("R1 busy", int'(busy_o), 0);
    check("R1 ready", int'(in_ready), 1);
    check("R1 done", int'(done_o), 0);
  endtask

  task automatic test_reject(input logic [1:0] kind);
    int f0, d0;
    f0 = fcnt; d0 = done_cnt;
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_byte = 8'h5A;
    check("R7 ready at reject", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3 * H) @(negedge clk);
    #1;
    check("R7 no frame", fcnt - f0, 0);
    check("R7 no done", done_cnt - d0, 0);
    check("R7 not busy", int'(busy_o), 0);
    check("R7 cs high", int'(cs_n_o), 1);
  endtask

  task automatic test_busy_ignore();
    int cyc, f0;
    f0 = fcnt;
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd1; in_byte = 8'h3C;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd0; in_byte = 8'hFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check("R8 ready low while busy", int'(in_ready), 0);
      check("R8 ready is not busy", int'(in_ready), int'(!busy_o));
    end
    in_valid = 1'b0;
    wait_done(cyc);
    frame_checks("busy ignore", 9'h13C);
    repeat (4 * H) @(negedge clk);
    #1;
    check("R8 no extra frame", fcnt - f0, 1);
  endtask

  task automatic test_back_to_back();
    int cyc;
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd0; in_byte = 8'h81;
    @(negedge clk);
    in_kind = 2'd1; in_byte = 8'h7E;
    wait_done(cyc);
    check("R9 first frame", int'(frames[(fcnt - 1) % 8]), 9'h081);
    check("R9 ready at done", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    wait_done(cyc);
    check("R9 one-cycle gap", gap_last, 1);
    frame_checks("R9 second", 9'h17E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send_one(2'd0, 8'h01, "cmd 01");
    send_one(2'd1, 8'hA5, "data A5");
    send_one(2'd1, 8'h00, "data 00");
    send_one(2'd0, 8'hFF, "cmd FF");
    send_one(2'd1, 8'h80, "data 80");
    test_reject(2'd2);
    test_reject(2'd3);
    test_busy_ignore();
    test_back_to_back();
    check("R4 phase lengths", bad_phase, 0);
    check("R4 sdo stable high", sdo_hi_chg, 0);
    check("R5 idle levels", idle_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule